// File: doc/BRIEF.md
# CPU status flag register

This block holds the eight-bit status word of a small processor core and computes its own arithmetic flag updates. Each cycle the execute stage presents an operation code, both ALU operands, the ALU result and the ALU carry-out. The block derives half carry, overflow, negative, zero, carry and sign from these values. A per-operation mask selects which flags the operation touches, and every other flag keeps its value.

Besides the arithmetic flags, the word carries a global interrupt gate and a one-bit scratch flag for single-bit moves. The interrupt gate is cleared by hardware when an interrupt is taken and set again on return. Software can also set or clear it with dedicated strobes. Pending requests from the individual sources reach the core only while the gate is open. The scratch flag is loaded from a chosen bit of a register operand. It can also be merged back into a chosen bit of an operand. The whole word can be read, and written in one cycle, through a direct port.

Top module: `cpu_status_reg`

## Requirements
- R1: Bit layout of `flags_o`: bit 7 interrupt gate (I), bit 6 scratch (T), bit 5 half carry (H), bit 4 sign (S), bit 3 overflow (V), bit 2 negative (N), bit 1 zero (Z), bit 0 carry (C). While `rst_ni` is low, and in the first cycle after reset, all eight bits read 0.
- R2: When `wr_en_i` is high, all eight bits take the value of `wr_data_i` at the next clock edge. This write overrides an ALU update, a bit store and the gate strobes in the same cycle. The one exception is an interrupt accept (see R3).
- R3: `int_ack_i` clears I at the next edge and wins over every other source. Otherwise a write sets I to `wr_data_i[7]`. Without a write, `ie_set_i` or `int_ret_i` sets I, and `ie_clr_i` alone clears it. Set wins over clear.
- R4: `irq_o` is `irq_i` AND I, combinationally.
- R5: For opcodes 0x01, 0x02, 0x03 and 0x04, N is set to `res_i[7]`, and Z is set when `res_i` is all zeros.
- R6: For opcode 0x01 (add), C is set to `cout_i`, and H is set to the carry from bit 3 into bit 4. V is set to (a7&b7&~r7)|(~a7&~b7&r7).
- R7: For opcode 0x02 (subtract), C is set to `cout_i` (the borrow), and H is set to the borrow from bit 4 into bit 3. V is set to (a7&~b7&~r7)|(~a7&b7&r7).
- R8: For opcode 0x03 (logic), V is cleared, and C and H keep their values.
- R9: For opcode 0x04 (shift right), C is set to `opa_i[0]`, V is set to N XOR C, and H keeps its value.
- R10: After any update of opcode 0x01 to 0x04, S equals N XOR V.
- R11: Opcode 0x00, and every opcode from 0x05 to 0xFF, leaves bits 5 to 0 unchanged.
- R12: `bst_i` loads T with `bit_src_i[bit_sel_i]` at the next edge, unless a write happens in the same cycle.
- R13: `bld_o` always equals `bit_src_i` with bit `bit_sel_i` replaced by the current T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alu_op_i | input | 8 | Operation code of the current ALU operation |
| opa_i | input | 8 | First ALU operand |
| opb_i | input | 8 | Second ALU operand |
| res_i | input | 8 | ALU result |
| cout_i | input | 1 | ALU carry-out or borrow |
| wr_en_i | input | 1 | Direct write strobe |
| wr_data_i | input | 8 | Direct write data |
| ie_set_i | input | 1 | Software set of the interrupt gate |
| ie_clr_i | input | 1 | Software clear of the interrupt gate |
| int_ack_i | input | 1 | Interrupt accepted strobe |
| int_ret_i | input | 1 | Return-from-interrupt strobe |
| irq_i | input | 1 | Pending interrupt request from the sources |
| bst_i | input | 1 | Bit store into the scratch flag |
| bit_sel_i | input | 3 | Bit position for store and load |
| bit_src_i | input | 8 | Register operand for store and load |
| flags_o | output | 8 | Status word, also the read port |
| irq_o | output | 1 | Gated interrupt request |
| bld_o | output | 8 | Operand with the scratch flag merged in |

## Verification
The hardest situation to reach is a collision: an interrupt accept, a direct write, the gate strobes, a bit store and an arithmetic update all in the same cycle. In that cycle the priority order alone decides the outcome. The stimulus first applies directed collisions, such as an accept together with a write that sets I, or a write together with a bit store. It then runs several thousand cycles in which each strobe fires independently at a low rate, so that multi-way overlaps occur many times. Directed operand pairs also hit the overflow and half-carry boundaries: 0x7F+0x01, 0xFF+0x01, 0x00-0x01 and 0x80-0x01.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int FW = 8;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;
  localparam int F_T = 6;
  localparam int F_I = 7;

  typedef enum logic [7:0] {
    OP_NOP   = 8'h00,
    OP_ADD   = 8'h01,
    OP_SUB   = 8'h02,
    OP_LOGIC = 8'h03,
    OP_LSR   = 8'h04
  } alu_op_e;

  // Same order as flags[5:0]
  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } arith_t;
endpackage

// File: rtl/sreg_flag_calc.sv
module sreg_flag_calc
  import sreg_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [7:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] r_i,
  input  logic          cout_i,
  input  arith_t        old_i,
  output arith_t        next_o
);
  localparam int MSB = DW - 1;
  localparam int HB  = 3;
  localparam int NF  = $bits(arith_t);

  arith_t val, msk, mrg;
  logic a_m, b_m, r_m, a_h, b_h, r_h;
  logic h_add, h_sub, v_add, v_sub;
  logic unused_opnd;

  assign unused_opnd = ^{a_i, b_i};

  assign a_m = a_i[MSB];
  assign b_m = b_i[MSB];
  assign r_m = r_i[MSB];
  assign a_h = a_i[HB];
  assign b_h = b_i[HB];
  assign r_h = r_i[HB];

  assign h_add = (a_h & b_h) | (b_h & ~r_h) | (~r_h & a_h);
  assign h_sub = (~a_h & b_h) | (b_h & r_h) | (r_h & ~a_h);
  assign v_add = (a_m & b_m & ~r_m) | (~a_m & ~b_m & r_m);
  assign v_sub = (a_m & ~b_m & ~r_m) | (~a_m & b_m & r_m);

  always_comb begin
    val   = '0;
    msk   = '0;
    val.n = r_m;
    val.z = ~|r_i;
    case (op_i)
      OP_ADD: begin
        val.h = h_add;
        val.v = v_add;
        val.c = cout_i;
        msk   = '1;
      end
      OP_SUB: begin
        val.h = h_sub;
        val.v = v_sub;
        val.c = cout_i;
        msk   = '1;
      end
      OP_LOGIC: begin
        val.v = 1'b0;
        msk.s = 1'b1;
        msk.v = 1'b1;
        msk.n = 1'b1;
        msk.z = 1'b1;
      end
      OP_LSR: begin
        val.c = a_i[0];
        val.v = r_m ^ a_i[0];
        msk.s = 1'b1;
        msk.v = 1'b1;
        msk.n = 1'b1;
        msk.z = 1'b1;
        msk.c = 1'b1;
      end
      default: msk = '0;
    endcase
  end

  for (genvar i = 0; i < NF; i++) begin : g_merge
    assign mrg[i] = msk[i] ? val[i] : old_i[i];
  end

  always_comb begin
    next_o = mrg;
    if (msk.s) next_o.s = mrg.n ^ mrg.v;
  end
endmodule

// File: rtl/sreg_ie_ctrl.sv
module sreg_ie_ctrl (
  input  logic ie_q_i,
  input  logic ack_i,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ret_i,
  input  logic irq_i,
  output logic ie_d_o,
  output logic irq_o
);
  always_comb begin
    if (ack_i)              ie_d_o = 1'b0;
    else if (wr_en_i)       ie_d_o = wr_bit_i;
    else if (set_i | ret_i) ie_d_o = 1'b1;
    else if (clr_i)         ie_d_o = 1'b0;
    else                    ie_d_o = ie_q_i;
  end

  assign irq_o = irq_i & ie_q_i;
endmodule

// File: rtl/sreg_bit_copy.sv
module sreg_bit_copy #(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic          t_q_i,
  input  logic          bst_i,
  input  logic [SW-1:0] sel_i,
  input  logic [DW-1:0] src_i,
  input  logic          wr_en_i,
  input  logic          wr_bit_i,
  output logic          t_d_o,
  output logic [DW-1:0] bld_o
);
  always_comb begin
    if (wr_en_i)    t_d_o = wr_bit_i;
    else if (bst_i) t_d_o = src_i[sel_i];
    else            t_d_o = t_q_i;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bld
    assign bld_o[i] = (sel_i == SW'(i)) ? t_q_i : src_i[i];
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import sreg_pkg::*;
#(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    alu_op_i,
  input  logic [DW-1:0] opa_i,
  input  logic [DW-1:0] opb_i,
  input  logic [DW-1:0] res_i,
  input  logic          cout_i,
  input  logic          wr_en_i,
  input  logic [FW-1:0] wr_data_i,
  input  logic          ie_set_i,
  input  logic          ie_clr_i,
  input  logic          int_ack_i,
  input  logic          int_ret_i,
  input  logic          irq_i,
  input  logic          bst_i,
  input  logic [SW-1:0] bit_sel_i,
  input  logic [DW-1:0] bit_src_i,
  output logic [FW-1:0] flags_o,
  output logic          irq_o,
  output logic [DW-1:0] bld_o
);
  logic [FW-1:0] flags_q, flags_d;
  arith_t        ar_next;
  logic          ie_d, t_d;

  sreg_flag_calc #(.DW(DW)) u_calc (
    .op_i   (alu_op_i),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .r_i    (res_i),
    .cout_i (cout_i),
    .old_i  (arith_t'(flags_q[F_H:F_C])),
    .next_o (ar_next)
  );

  sreg_ie_ctrl u_ie (
    .ie_q_i   (flags_q[F_I]),
    .ack_i    (int_ack_i),
    .wr_en_i  (wr_en_i),
    .wr_bit_i (wr_data_i[F_I]),
    .set_i    (ie_set_i),
    .clr_i    (ie_clr_i),
    .ret_i    (int_ret_i),
    .irq_i    (irq_i),
    .ie_d_o   (ie_d),
    .irq_o    (irq_o)
  );

  sreg_bit_copy #(.DW(DW)) u_bit (
    .t_q_i    (flags_q[F_T]),
    .bst_i    (bst_i),
    .sel_i    (bit_sel_i),
    .src_i    (bit_src_i),
    .wr_en_i  (wr_en_i),
    .wr_bit_i (wr_data_i[F_T]),
    .t_d_o    (t_d),
    .bld_o    (bld_o)
  );

  always_comb begin
    flags_d           = flags_q;
    flags_d[F_I]      = ie_d;
    flags_d[F_T]      = t_d;
    flags_d[F_H:F_C]  = wr_en_i ? wr_data_i[F_H:F_C] : ar_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/cpu_status_reg_chk.sv
module cpu_status_reg_chk #(
  parameter int DW = 8,
  localparam int SW = $clog2(DW)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    alu_op_i,
  input logic          wr_en_i,
  input logic [7:0]    wr_data_i,
  input logic          int_ack_i,
  input logic          int_ret_i,
  input logic          bst_i,
  input logic [SW-1:0] bit_sel_i,
  input logic [DW-1:0] bit_src_i,
  input logic [7:0]    flags_o,
  input logic          irq_o
);
  logic known_op;
  assign known_op = (alu_op_i >= 8'h01) && (alu_op_i <= 8'h04);

  assert_ack_clears_ie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_i |=> !flags_o[7]);

  assert_ret_sets_ie_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_ret_i && !int_ack_i && !wr_en_i) |=> flags_o[7]);

  assert_irq_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags_o[7] |-> !irq_o);

  assert_write_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !int_ack_i) |=> flags_o == $past(wr_data_i));

  assert_sign_rule_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (known_op && !wr_en_i) |=> flags_o[4] == (flags_o[2] ^ flags_o[3]));

  assert_logic_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_i == 8'h03 && !wr_en_i) |=>
      (!flags_o[3] && flags_o[0] == $past(flags_o[0]) && flags_o[5] == $past(flags_o[5])));

  assert_other_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!known_op && !wr_en_i) |=> flags_o[5:0] == $past(flags_o[5:0]));

  assert_bit_store_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bst_i && !wr_en_i) |=> flags_o[6] == $past(bit_src_i[bit_sel_i]));
endmodule

bind cpu_status_reg cpu_status_reg_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .alu_op_i  (alu_op_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .int_ack_i (int_ack_i),
  .int_ret_i (int_ret_i),
  .bst_i     (bst_i),
  .bit_sel_i (bit_sel_i),
  .bit_src_i (bit_src_i),
  .flags_o   (flags_o),
  .irq_o     (irq_o)
);

// File: tb/sim_cpu_status_reg.sv
module sim_cpu_status_reg;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [7:0] alu_op_i, opa_i, opb_i, res_i, wr_data_i, bit_src_i;
  logic       cout_i, wr_en_i, ie_set_i, ie_clr_i, int_ack_i, int_ret_i, irq_i, bst_i;
  logic [2:0] bit_sel_i;
  logic [7:0] flags_o, bld_o;
  logic       irq_o;

  logic [7:0] exp_f;
  logic       cin;
  int         n_vec = 0;
  int         n_bad = 0;
  bit         done  = 0;

  always #10 clk_i = ~clk_i;

  cpu_status_reg u0 (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic idle();
    alu_op_i = 8'h00; opa_i = '0; opb_i = '0; res_i = '0; cout_i = 1'b0; cin = 1'b0;
    wr_en_i = 1'b0; wr_data_i = '0; ie_set_i = 1'b0; ie_clr_i = 1'b0;
    int_ack_i = 1'b0; int_ret_i = 1'b0; irq_i = 1'b0; bst_i = 1'b0;
    bit_sel_i = '0; bit_src_i = '0;
  endtask

  task automatic set_alu(logic [7:0] op, logic [7:0] a, logic [7:0] b, logic ci, logic [7:0] other);
    logic [8:0] w;
    alu_op_i = op; opa_i = a; opb_i = b; cin = ci;
    case (op)
      8'h01: begin w = 9'(a) + 9'(b) + 9'(ci); res_i = w[7:0]; cout_i = w[8]; end
      8'h02: begin w = 9'(a) - 9'(b) - 9'(ci); res_i = w[7:0]; cout_i = w[8]; end
      8'h04: begin res_i = a >> 1; cout_i = other[0]; end
      default: begin res_i = other; cout_i = other[7]; end
    endcase
  endtask

  function automatic int sgn(logic [7:0] x);
    return (x >= 128) ? int'(x) - 256 : int'(x);
  endfunction

  // Behavioural next-state model, then compare after the edge
  task automatic step();
    logic [7:0] nx;
    int sr;
    string ta, tn, ts;
    @(posedge clk_i);
    nx = exp_f;
    ta = "R11"; tn = "R11"; ts = "R11";
    if (alu_op_i >= 8'h01 && alu_op_i <= 8'h04) begin
      nx[2] = res_i[7];
      nx[1] = (res_i == 8'h00);
      tn = "R5"; ts = "R10";
      case (alu_op_i)
        8'h01: begin
          ta = "R6";
          nx[0] = (int'(opa_i) + int'(opb_i) + int'(cin)) > 255;
          nx[5] = (int'(opa_i % 16) + int'(opb_i % 16) + int'(cin)) > 15;
          sr = sgn(opa_i) + sgn(opb_i) + int'(cin);
          nx[3] = (sr > 127) || (sr < -128);
        end
        8'h02: begin
          ta = "R7";
          nx[0] = int'(opa_i) < int'(opb_i) + int'(cin);
          nx[5] = int'(opa_i % 16) < int'(opb_i % 16) + int'(cin);
          sr = sgn(opa_i) - sgn(opb_i) - int'(cin);
          nx[3] = (sr > 127) || (sr < -128);
        end
        8'h03: begin ta = "R8"; nx[3] = 1'b0; end
        default: begin ta = "R9"; nx[0] = opa_i[0]; nx[3] = nx[2] ^ nx[0]; end
      endcase
      nx[4] = nx[2] ^ nx[3];
    end
    if (bst_i) nx[6] = bit_src_i[bit_sel_i];
    if (ie_set_i || int_ret_i) nx[7] = 1'b1;
    else if (ie_clr_i) nx[7] = 1'b0;
    if (wr_en_i) begin nx = wr_data_i; ta = "R2"; tn = "R2"; ts = "R2"; end
    if (int_ack_i) nx[7] = 1'b0;
    exp_f = nx;
    @(negedge clk_i);
    chk(ta, flags_o & 8'h29, exp_f & 8'h29);
    chk(tn, flags_o & 8'h06, exp_f & 8'h06);
    chk(ts, flags_o & 8'h10, exp_f & 8'h10);
    chk(wr_en_i ? "R2_T" : "R12", flags_o & 8'h40, exp_f & 8'h40);
    chk("R3", flags_o & 8'h80, exp_f & 8'h80);
    chk("R4", {7'd0, irq_o}, {7'd0, irq_i & exp_f[7]});
    begin
      logic [7:0] eb;
      eb = bit_src_i;
      eb[bit_sel_i] = exp_f[6];
      chk("R13", bld_o, eb);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    exp_f  = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1", flags_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", flags_o, 8'h00);

    // R6: 0x7F + 0x01 -> H V N set, S C Z clear
    set_alu(8'h01, 8'h7F, 8'h01, 1'b0, 8'h00); step();
    chk("R6", flags_o & 8'h3F, 8'h2C);
    // R6: 0xFF + 0x01 -> H Z C
    set_alu(8'h01, 8'hFF, 8'h01, 1'b0, 8'h00); step();
    chk("R6", flags_o & 8'h3F, 8'h23);
    // R7: 0x00 - 0x01 -> H S N C
    set_alu(8'h02, 8'h00, 8'h01, 1'b0, 8'h00); step();
    chk("R7", flags_o & 8'h3F, 8'h35);
    // R7: 0x80 - 0x01 -> overflow
    set_alu(8'h02, 8'h80, 8'h01, 1'b0, 8'h00); step();
    chk("R7", flags_o & 8'h3F, 8'h38);
    // R8: logic keeps H and C
    set_alu(8'h03, 8'h00, 8'h00, 1'b0, 8'h00); step();
    // R9: shift of 0x01
    set_alu(8'h04, 8'h01, 8'h00, 1'b0, 8'h00); step();
    chk("R9", flags_o & 8'h1F, 8'h1B);
    // R11: unlisted opcodes
    set_alu(8'h05, 8'h00, 8'h00, 1'b0, 8'h00); step();
    set_alu(8'hFF, 8'h12, 8'h34, 1'b1, 8'h00); step();
    idle();
    // R3 and R4: set gate, request passes, accept with write of I=1
    ie_set_i = 1'b1; irq_i = 1'b1; step();
    ie_set_i = 1'b0; step();
    int_ack_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'hFF; step();
    chk("R3", flags_o, 8'h7F);
    idle(); int_ret_i = 1'b1; ie_clr_i = 1'b1; step();
    idle(); ie_clr_i = 1'b1; irq_i = 1'b1; step();
    // R2 over R12: write and bit store together
    idle(); wr_en_i = 1'b1; wr_data_i = 8'h00; bst_i = 1'b1; bit_src_i = 8'hFF; bit_sel_i = 3'd5; step();
    // R12 and R13 over every position
    for (int i = 0; i < 8; i++) begin
      idle(); bst_i = 1'b1; bit_sel_i = 3'(i); bit_src_i = 8'(1 << i); step();
      idle(); bit_sel_i = 3'(7 - i); bit_src_i = 8'h00; step();
    end

    for (int k = 0; k < 4000; k++) begin
      logic [7:0] rop;
      idle();
      rop = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 6);
      set_alu(rop, 8'($urandom), 8'($urandom), 1'($urandom), 8'($urandom));
      wr_en_i   = ($urandom % 16) == 0;
      wr_data_i = 8'($urandom);
      ie_set_i  = ($urandom % 8) == 0;
      ie_clr_i  = ($urandom % 8) == 0;
      int_ret_i = ($urandom % 8) == 0;
      int_ack_i = ($urandom % 12) == 0;
      irq_i     = 1'($urandom);
      bst_i     = ($urandom % 4) == 0;
      bit_sel_i = 3'($urandom);
      bit_src_i = 8'($urandom);
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule